// File: doc/BRIEF.md
# Interlocked-Handshake Register Slave

This block is a slave on a bus where every transfer is a four-phase interlock between a master strobe and a slave acknowledge. The master sets up a byte address, a direction flag and, for writes, a data word, and only then raises its strobe. The slave brings the strobe into its own clock domain through a two-stage synchroniser. Address, direction and data are used only once the synchronised strobe is seen high.

The slave owns four 16-bit registers that sit at consecutive word addresses from a parameterised, aligned base. On a write it loads the addressed register in the cycle it recognises the strobe, and raises the acknowledge in that same cycle. On a read it drives the register onto its data output and raises a drive-enable together with the acknowledge. When the master drops its strobe, the acknowledge, the drive-enable and the data all return to idle in one cycle, so the master can start its next transfer.

Word accesses ignore the byte bit of the address. An address outside the window gets no acknowledge at all, which leaves the master's own timeout to end the transfer.

Top module: `ilk_slave_port`

## Requirements
- R1: While reset is high and right after it, the acknowledge, the drive-enable and the read data output are 0, and all four registers read back as 0.
- R2: On a write (direction flag 1) inside the window, the addressed register takes the data input and the acknowledge rises on the third rising clock edge after the strobe input goes high. Both happen in the same cycle.
- R3: On a read (direction flag 0) inside the window, the drive-enable rises in the same cycle as the acknowledge, and the data output equals the addressed register. A write cycle never raises the drive-enable.
- R4: The acknowledge, the drive-enable and the data output all return to 0 on the third rising edge after the strobe input goes low.
- R5: While the strobe stays high after the acknowledge, the acknowledge stays high and the read data stays constant. A new acknowledge needs the strobe to go low and then high again.
- R6: Address bit 0 is ignored, so odd byte address BASE+2k+1 reaches the same register as BASE+2k.
- R7: A byte address outside BASE..BASE+7 produces no acknowledge and no drive-enable, and leaves every register unchanged.
- R8: Register k (k = 0..3) is at byte address BASE+2k, and each register holds its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_strobe | input | 1 | Master strobe, asynchronous to clk |
| bus_addr | input | 18 | Byte address |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | input | 16 | Write data from master |
| bus_ack | output | 1 | Slave acknowledge |
| bus_rdata | output | 16 | Read data, 0 when not driving |
| bus_rdrive | output | 1 | Read data enable, high with the acknowledge on reads |

## Verification
Writes use all-ones, all-zeros, alternating and walking-one words, each to a different register. Reading them back shows whether the registers are independent and whether the index is decoded correctly. The same registers are reached from odd byte addresses, which shows whether bit 0 is ignored rather than taken as part of the index. Addresses just above and just below the window show whether the edges of the window are decoded. Read-backs after those misses show that nothing was written. One read holds the strobe well past the acknowledge, which shows whether the slave waits for the strobe to drop or releases on its own.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    localparam int DATA_W = 16;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_HELD = 1'b1
    } phase_e;

    typedef struct packed {
        logic  ack;
        logic  drive;
        word_t data;
    } reply_t;

    function automatic reply_t idle_reply();
        reply_t r;
        r.ack   = 1'b0;
        r.drive = 1'b0;
        r.data  = '0;
        return r;
    endfunction
endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ilk_decode.sv
module ilk_decode #(
    parameter int                ADDR_W = 18,
    parameter int                N_REGS = 4,
    parameter logic [ADDR_W-1:0] BASE   = 18'h3FF70,
    localparam int               IDX_W  = $clog2(N_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int TOP_LSB = IDX_W + 1;

    assign hit = (addr[ADDR_W-1:TOP_LSB] == BASE[ADDR_W-1:TOP_LSB]);
    assign idx = addr[IDX_W:1];
endmodule

// File: rtl/ilk_regbank.sv
module ilk_regbank
    import ilk_pkg::*;
#(
    parameter int  N_REGS = 4,
    localparam int IDX_W  = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t regs [N_REGS];

    generate
        for (genvar k = 0; k < N_REGS; k++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                         regs[k] <= '0;
                else if (we && idx == IDX_W'(k)) regs[k] <= wdata;
            end
        end
    endgenerate

    assign rdata = regs[idx];
endmodule

// File: rtl/ilk_slave_port.sv
module ilk_slave_port
    import ilk_pkg::*;
#(
    parameter int                ADDR_W = 18,
    parameter int                N_REGS = 4,
    parameter logic [ADDR_W-1:0] BASE   = 18'h3FF70,
    parameter int                SYNC_N = 2,
    localparam int               IDX_W  = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdrive
);
    logic             strobe_s;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             take;
    logic             we;
    word_t            bank_rdata;
    phase_e           phase;
    reply_t           reply;

    ilk_sync #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_strobe),
        .q   (strobe_s)
    );

    ilk_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    assign take = (phase == PH_IDLE) && strobe_s && hit;
    assign we   = take && bus_write;

    ilk_regbank #(.N_REGS(N_REGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .idx   (idx),
        .wdata (bus_wdata),
        .rdata (bank_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            reply <= idle_reply();
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (take) begin
                        phase       <= PH_HELD;
                        reply.ack   <= 1'b1;
                        reply.drive <= !bus_write;
                        reply.data  <= bus_write ? '0 : bank_rdata;
                    end
                end
                PH_HELD: begin
                    if (!strobe_s) begin
                        phase <= PH_IDLE;
                        reply <= idle_reply();
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    reply <= idle_reply();
                end
            endcase
        end
    end

    assign bus_ack    = reply.ack;
    assign bus_rdrive = reply.drive;
    assign bus_rdata  = reply.data;
endmodule

// File: rtl/ilk_slave_port_chk.sv
module ilk_slave_port_chk
    import ilk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        strobe_s,
    input logic        hit,
    input logic        bus_ack,
    input logic        bus_rdrive,
    input logic [DATA_W-1:0] bus_rdata
);
    assert_drive_needs_ack_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rdrive |-> bus_ack);

    assert_no_late_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !bus_rdrive) |=> !bus_rdrive);

    assert_data_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_rdrive |-> (bus_rdata == '0));

    assert_ack_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(strobe_s));

    assert_ack_only_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(hit));

    assert_release_on_drop_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ack) |-> !$past(strobe_s));

    assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && $past(bus_ack)) |-> $stable(bus_rdata));
endmodule

bind ilk_slave_port ilk_slave_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_s   (strobe_s),
    .hit        (hit),
    .bus_ack    (bus_ack),
    .bus_rdrive (bus_rdrive),
    .bus_rdata  (bus_rdata)
);

// File: tb/test_ilk_slave_port.sv
`timescale 1ns/1ps
module test_ilk_slave_port;
    localparam int          AW   = 18;
    localparam logic [17:0] BASE = 18'h3FF70;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [17:0] addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic        rdrive;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ilk_slave_port #(.ADDR_W(AW), .BASE(BASE)) i_ilk_slave_port (
        .clk        (clk),
        .rst        (rst),
        .bus_strobe (strobe),
        .bus_addr   (addr),
        .bus_write  (wr),
        .bus_wdata  (wdata),
        .bus_ack    (ack),
        .bus_rdata  (rdata),
        .bus_rdrive (rdrive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: strobe seen after two clocks of delay.
    int    mem [4];
    int    hist [$];
    bit    m_ack, m_drv;
    int    m_data;

    function automatic bit in_win(input logic [17:0] a);
        return (a >> 3) == (BASE >> 3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (mem[i]) mem[i] = 0;
            hist = {0, 0};
            m_ack = 0; m_drv = 0; m_data = 0;
        end else begin
            int seen;
            seen = hist.pop_front();
            hist.push_back(int'(strobe));
            if (!m_ack) begin
                if (seen != 0 && in_win(addr)) begin
                    int k;
                    k = int'((addr >> 1) & 18'h3);
                    m_ack = 1;
                    if (wr) mem[k] = int'(wdata);
                    else begin m_drv = 1; m_data = mem[k]; end
                end
            end else if (seen == 0) begin
                m_ack = 0; m_drv = 0; m_data = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(ack == m_ack, "R2", "per-cycle ack", int'(ack), int'(m_ack));
            chk(rdrive == m_drv, "R3", "per-cycle drive", int'(rdrive), int'(m_drv));
            chk(int'(rdata) == m_data, "R4", "per-cycle data", int'(rdata), m_data);
        end
    end

    task automatic cycle(input logic [17:0] a, input logic w, input logic [15:0] d,
                         input int hold, input bit exp_ack, input int exp_rd,
                         input string req);
        int lat;
        logic [15:0] first;
        @(negedge clk);
        addr = a; wr = w; wdata = d;
        @(negedge clk);
        strobe = 1'b1;
        lat = 0;
        while (!ack && lat < 20) begin @(negedge clk); lat++; end
        if (!exp_ack) begin
            chk(!ack, req, "no ack outside window", int'(ack), 0);
            chk(!rdrive, req, "no drive outside window", int'(rdrive), 0);
        end else begin
            chk(lat == 3, "R2", "ack latency", lat, 3);
            chk(rdrive == !w, "R3", "drive with ack", int'(rdrive), int'(!w));
            if (!w) chk(int'(rdata) == exp_rd, req, "read data", int'(rdata), exp_rd);
            first = rdata;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk(ack && rdata == first, "R5", "held ack/data",
                    int'(rdata), int'(first));
            end
        end
        strobe = 1'b0;
        lat = 0;
        while (ack && lat < 20) begin @(negedge clk); lat++; end
        if (exp_ack) chk(lat == 3, "R4", "release latency", lat, 3);
        chk(!rdrive && rdata == 0, "R4", "idle after release", int'(rdata), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'hFFFF; pats[1] = 16'h0000;
        pats[2] = 16'hA5A5; pats[3] = 16'h0100;

        repeat (3) @(negedge clk);
        chk(!ack && !rdrive && rdata == 0, "R1", "outputs in reset", int'(rdata), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ack && !rdrive && rdata == 0, "R1", "outputs after reset", int'(rdata), 0);

        for (int k = 0; k < 4; k++)
            cycle(BASE + 18'(2*k), 1'b0, 16'h0, 0, 1, 0, "R1");

        for (int k = 0; k < 4; k++)
            cycle(BASE + 18'(2*k), 1'b1, pats[k], 0, 1, 0, "R2");
        for (int k = 0; k < 4; k++)
            cycle(BASE + 18'(2*k), 1'b0, 16'h0, 0, 1, int'(pats[k]), "R8");

        cycle(BASE + 18'd5, 1'b1, 16'h5A5A, 0, 1, 0, "R6");
        cycle(BASE + 18'd4, 1'b0, 16'h0, 0, 1, 16'h5A5A, "R6");
        cycle(BASE + 18'd1, 1'b0, 16'h0, 0, 1, int'(pats[0]), "R6");
        cycle(BASE + 18'd7, 1'b0, 16'h0, 0, 1, int'(pats[3]), "R6");

        cycle(BASE + 18'd8, 1'b1, 16'h1234, 0, 0, 0, "R7");
        cycle(BASE - 18'd2, 1'b1, 16'h4321, 0, 0, 0, "R7");
        cycle(BASE - 18'd1, 1'b0, 16'h0, 0, 0, 0, "R7");
        cycle(BASE, 1'b0, 16'h0, 0, 1, int'(pats[0]), "R7");
        cycle(BASE + 18'd2, 1'b0, 16'h0, 0, 1, int'(pats[1]), "R7");
        cycle(BASE + 18'd4, 1'b0, 16'h0, 0, 1, 16'h5A5A, "R7");
        cycle(BASE + 18'd6, 1'b0, 16'h0, 0, 1, int'(pats[3]), "R7");

        cycle(BASE + 18'd4, 1'b0, 16'h0, 10, 1, 16'h5A5A, "R5");
        cycle(BASE + 18'd6, 1'b1, 16'hC3C3, 6, 1, 0, "R5");
        cycle(BASE + 18'd6, 1'b0, 16'h0, 0, 1, 16'hC3C3, "R3");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule